// File: doc/BRIEF.md
# Button-Selected Timed LED Sequencer

This block drives a row of eight LEDs that fill up one position per interval, following one of two fill orders chosen with two active-low push buttons. A single active-low seven-segment digit shows the number of the chosen order. The interval comes from a modulo counter that issues a one-cycle enable each time it wraps. With a 50 MHz clock and the default wrap value, that is one step per second.

Each button passes through a two-flop synchronizer. Only a press, meaning a high-to-low transition, counts as an event. A press clears the LEDs, restarts the interval counter and loads the chosen order. In order 1 every LED lights, from bit 0 up to bit 7. In order 2 only bits 1, 2, 4, 5 and 7 light, in ascending order. After the last step the LEDs hold until the next press or reset.

The controller has three states:
- `ST_IDLE`: after reset, with the digit blank.
- `ST_RUN`: filling.
- `ST_HOLD`: fully lit.

Its transitions:
- IDLE→RUN on a press.
- RUN→RUN on a press, which is a restart.
- RUN→HOLD on the tick that lights the last position.
- HOLD→RUN on a press.

Top module: `led_step_sequencer`

## Requirements
- R1: While `rst` is high, and after it until the first press, `leds` is 8'h00 and `seg_n` is 7'b1111111 (blank). `seg_n` bit 0 is segment a and bit 6 is segment g, and a segment is lit when its bit is 0.
- R2: Driving `key_one_n` low selects order 1. On the third rising edge after the low level is first sampled, `seg_n` becomes 7'b1111001 (digit 1).
- R3: A press on `key_two_n` selects order 2 with the same latency, and `seg_n` becomes 7'b0100100 (digit 2).
- R4: The edge that registers a press clears `leds` to 8'h00 and restarts the interval counter from zero.
- R5: The first position lights TICK_WRAP+1 cycles after the edge that registers the press. Each further position lights TICK_WRAP+1 cycles after the previous one, and only one position changes per step.
- R6: Order 1 lights bits 0,1,…,7 cumulatively: 01, 03, 07, 0F, 1F, 3F, 7F, FF.
- R7: Order 2 lights only bits 1, 2, 4, 5, 7 cumulatively: 02, 06, 16, 36, B6.
- R8: After the last step, `leds` stays at the full pattern until a press or reset.
- R9: A press during a running fill restarts it at once with the newly chosen order.
- R10: If both buttons are first seen low in the same cycle, order 1 wins.
- R11: A button held low produces only one press, and releasing it has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| key_one_n | input | 1 | Button selecting order 1, active low |
| key_two_n | input | 1 | Button selecting order 2, active low |
| leds | output | 8 | LED drive, bit 0 is the first LED, active high |
| seg_n | output | 7 | Digit segments a..g in bits 0..6, active low |

## Verification
The bench builds the block with `TICK_WRAP` = 3, so a step takes four cycles instead of fifty million. Both complete fill orders, hold periods and restarts then fit in a few hundred cycles. With this short period, the exact cycle of the first step can be checked edge by edge. Restarts in mid-fill, simultaneous presses and long holds of a button can also be run to completion.

// File: rtl/seqr_pkg.sv
package seqr_pkg;

    localparam int SEG_W = 7;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_HOLD
    } seq_state_e;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_ONE,
        SEL_TWO
    } pat_sel_e;

    localparam logic [SEG_W-1:0] SEG_BLANK = 7'b1111111;
    localparam logic [SEG_W-1:0] SEG_DIG1  = 7'b1111001;
    localparam logic [SEG_W-1:0] SEG_DIG2  = 7'b0100100;

endpackage

// File: rtl/key_sync_edge.sv
module key_sync_edge #(
    parameter int N_KEYS      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_KEYS-1:0] keys_n,
    output logic [N_KEYS-1:0] press
);

    for (genvar k = 0; k < N_KEYS; k++) begin : g_key
        logic [SYNC_STAGES-1:0] chain_q;
        logic                   last_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain_q <= '1;
                last_q  <= 1'b1;
            end else begin
                chain_q <= {chain_q[SYNC_STAGES-2:0], keys_n[k]};
                last_q  <= chain_q[SYNC_STAGES-1];
            end
        end

        assign press[k] = last_q & ~chain_q[SYNC_STAGES-1];

        // R11
        press_pulse_chk: assert property (@(posedge clk) disable iff (rst)
            press[k] |=> !press[k]);
    end

endmodule

// File: rtl/tick_gen.sv
module tick_gen #(
    parameter int TICK_WRAP = 49_999_999
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);

    localparam int CW = (TICK_WRAP < 1) ? 1 : $clog2(TICK_WRAP + 1);
    localparam logic [CW-1:0] WRAP_V = CW'(TICK_WRAP);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (cnt_q == WRAP_V) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign tick = (cnt_q == WRAP_V);

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= WRAP_V);

    // R5
    tick_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R4
    clr_restart_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> !tick);

endmodule

// File: rtl/step_fsm.sv
module step_fsm
    import seqr_pkg::*;
#(
    parameter int              LED_W    = 8,
    parameter logic [LED_W-1:0] MASK_TWO = 8'b1011_0110
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_one,
    input  logic             start_two,
    input  logic             tick,
    output logic [LED_W-1:0] leds,
    output pat_sel_e         sel,
    output seq_state_e       state
);

    localparam logic [LED_W-1:0] MASK_ONE = '1;

    seq_state_e       state_q, state_d;
    logic [LED_W-1:0] leds_q, mask_q;
    pat_sel_e         sel_q;

    logic             start_any;
    logic [LED_W-1:0] remaining, next_bit;
    logic             last_step;

    assign start_any = start_one | start_two;
    assign remaining = mask_q & ~leds_q;
    assign next_bit  = remaining & (~remaining + LED_W'(1));
    assign last_step = ((leds_q | next_bit) == mask_q);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_any) state_d = ST_RUN;
            ST_RUN: begin
                if (start_any)              state_d = ST_RUN;
                else if (tick && last_step) state_d = ST_HOLD;
            end
            ST_HOLD: if (start_any) state_d = ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            leds_q <= '0;
            mask_q <= '0;
            sel_q  <= SEL_NONE;
        end else if (start_any) begin
            leds_q <= '0;
            mask_q <= start_one ? MASK_ONE : MASK_TWO;
            sel_q  <= start_one ? SEL_ONE : SEL_TWO;
        end else if (state_q == ST_RUN && tick) begin
            leds_q <= leds_q | next_bit;
        end
    end

    assign leds  = leds_q;
    assign sel   = sel_q;
    assign state = state_q;

    // R6 R7
    leds_in_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (leds_q & ~mask_q) == '0);

    // R5
    one_step_chk: assert property (@(posedge clk) disable iff (rst)
        !start_any |=> ($countones(leds_q ^ $past(leds_q)) <= 1));

    // R5
    grow_only_chk: assert property (@(posedge clk) disable iff (rst)
        !start_any |=> (($past(leds_q) & ~leds_q) == '0));

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD && !start_any) |=> $stable(leds_q));

    // R4
    clear_on_start_chk: assert property (@(posedge clk) disable iff (rst)
        start_any |=> (leds_q == '0 && state_q == ST_RUN));

    // R10
    priority_chk: assert property (@(posedge clk) disable iff (rst)
        (start_one && start_two) |=> (sel_q == SEL_ONE));

endmodule

// File: rtl/seg_encoder.sv
module seg_encoder
    import seqr_pkg::*;
(
    input  pat_sel_e         sel,
    output logic [SEG_W-1:0] seg_n
);

    always_comb begin
        unique case (sel)
            SEL_ONE: seg_n = SEG_DIG1;
            SEL_TWO: seg_n = SEG_DIG2;
            default: seg_n = SEG_BLANK;
        endcase
    end

endmodule

// File: rtl/led_step_sequencer.sv
module led_step_sequencer
    import seqr_pkg::*;
#(
    parameter int               TICK_WRAP   = 49_999_999,
    parameter int               LED_W       = 8,
    parameter int               SYNC_STAGES = 2,
    parameter logic [LED_W-1:0] MASK_TWO    = 8'b1011_0110
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             key_one_n,
    input  logic             key_two_n,
    output logic [LED_W-1:0] leds,
    output logic [SEG_W-1:0] seg_n
);

    logic [1:0] press;
    logic       start_one, start_two, tick;
    pat_sel_e   sel;
    seq_state_e state;

    key_sync_edge #(
        .N_KEYS     (2),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_keys (
        .clk   (clk),
        .rst   (rst),
        .keys_n({key_two_n, key_one_n}),
        .press (press)
    );

    assign start_one = press[0];
    assign start_two = press[1];

    tick_gen #(
        .TICK_WRAP(TICK_WRAP)
    ) u_tick (
        .clk (clk),
        .rst (rst),
        .clr (start_one | start_two),
        .tick(tick)
    );

    step_fsm #(
        .LED_W   (LED_W),
        .MASK_TWO(MASK_TWO)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start_one(start_one),
        .start_two(start_two),
        .tick     (tick),
        .leds     (leds),
        .sel      (sel),
        .state    (state)
    );

    seg_encoder u_seg (
        .sel  (sel),
        .seg_n(seg_n)
    );

    // R1
    idle_blank_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (seg_n == SEG_BLANK && leds == '0));

    // R2 R3
    lit_shows_digit_chk: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |-> (seg_n != SEG_BLANK));

endmodule

// File: tb/test_led_step_sequencer.sv
`timescale 1ns/1ps
module test_led_step_sequencer;

    localparam int WRAP = 3;
    localparam logic [6:0] BL = 7'b1111111;
    localparam logic [6:0] D1 = 7'b1111001;
    localparam logic [6:0] D2 = 7'b0100100;
    localparam int NV = 18;

    // {key_one_n, key_two_n, waits[7:0], leds[7:0], seg[6:0], req[3:0]}
    localparam logic [28:0] VEC [0:NV-1] = '{
        {1'b1, 1'b1, 8'd2,  8'h00, BL, 4'd1},   // R1 after reset
        {1'b0, 1'b1, 8'd3,  8'h00, D1, 4'd2},   // R2 press one
        {1'b1, 1'b1, 8'd4,  8'h01, D1, 4'd6},   // R6
        {1'b1, 1'b1, 8'd4,  8'h03, D1, 4'd6},
        {1'b1, 1'b1, 8'd4,  8'h07, D1, 4'd6},
        {1'b1, 1'b1, 8'd4,  8'h0F, D1, 4'd6},
        {1'b1, 1'b1, 8'd4,  8'h1F, D1, 4'd6},
        {1'b1, 1'b1, 8'd4,  8'h3F, D1, 4'd6},
        {1'b1, 1'b1, 8'd4,  8'h7F, D1, 4'd6},
        {1'b1, 1'b1, 8'd4,  8'hFF, D1, 4'd6},
        {1'b1, 1'b1, 8'd12, 8'hFF, D1, 4'd8},   // R8 hold
        {1'b1, 1'b0, 8'd3,  8'h00, D2, 4'd3},   // R3 and R4 clear
        {1'b1, 1'b1, 8'd4,  8'h02, D2, 4'd7},   // R7
        {1'b1, 1'b1, 8'd4,  8'h06, D2, 4'd7},
        {1'b1, 1'b1, 8'd4,  8'h16, D2, 4'd7},
        {1'b1, 1'b1, 8'd4,  8'h36, D2, 4'd7},
        {1'b1, 1'b1, 8'd4,  8'hB6, D2, 4'd7},
        {1'b1, 1'b1, 8'd12, 8'hB6, D2, 4'd8}    // R8 hold
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       k1n = 1'b1;
    logic       k2n = 1'b1;
    logic [7:0] leds;
    logic [6:0] seg_n;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;

    led_step_sequencer #(.TICK_WRAP(WRAP)) i_led_step_sequencer (
        .clk      (clk),
        .rst      (rst),
        .key_one_n(k1n),
        .key_two_n(k2n),
        .leds     (leds),
        .seg_n    (seg_n)
    );

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic [7:0] el, input logic [6:0] es, input string tag);
        checks++;
        if (leds !== el || seg_n !== es) begin
            fails++;
            $display("FAIL %s: leds=%h seg_n=%b expected leds=%h seg_n=%b",
                     tag, leds, seg_n, el, es);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(8'h00, BL, "R1 in reset");
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [28:0] v;
            v   = VEC[i];
            k1n = v[28];
            k2n = v[27];
            waitn(int'(v[26:19]));
            chk(v[18:11], v[10:4], $sformatf("R%0d vector %0d", v[3:0], i));
        end

        // R5 exact step timing
        k1n = 1'b0;
        waitn(3); chk(8'h00, D1, "R5 restart edge");
        k1n = 1'b1;
        waitn(3); chk(8'h00, D1, "R5 one cycle before first step");
        waitn(1); chk(8'h01, D1, "R5 first step");
        waitn(3); chk(8'h01, D1, "R5 one cycle before second step");
        waitn(1); chk(8'h03, D1, "R5 second step");

        // R9 restart in mid-fill with the other order
        k2n = 1'b0;
        waitn(3); chk(8'h00, D2, "R9 restart clears");
        k2n = 1'b1;
        waitn(4); chk(8'h02, D2, "R9 new order first step");

        // R10 both buttons together
        k1n = 1'b0; k2n = 1'b0;
        waitn(3); chk(8'h00, D1, "R10 first button wins");
        k1n = 1'b1; k2n = 1'b1;
        waitn(4); chk(8'h01, D1, "R10 order one runs");

        // R11 held button, then release
        k1n = 1'b0;
        waitn(3); chk(8'h00, D1, "R11 press while held");
        waitn(4); chk(8'h01, D1, "R11 held, step one");
        waitn(28); chk(8'hFF, D1, "R11 held, full");
        waitn(20); chk(8'hFF, D1, "R11 held, no retrigger");
        k1n = 1'b1;
        waitn(8); chk(8'hFF, D1, "R11 release ignored");

        // R1 reset mid-run
        k2n = 1'b0;
        waitn(6);
        rst = 1'b1;
        waitn(2); chk(8'h00, BL, "R1 reset mid-run");
        k2n = 1'b1;
        rst = 1'b0;
        waitn(10); chk(8'h00, BL, "R1 idle after reset");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule